// File: doc/BRIEF.md
# SPI Master Register and Status Front End

This block is the software-visible side of an SPI master. A 32-bit word-aligned register bus reaches a set of control and configuration registers, a transmit data port that fills a word FIFO, and a receive data port that drains a second word FIFO. A separate transfer engine, which does the serial shifting, pops transmit words from one FIFO and pushes received words into the other. Software sees FIFO fill state and two sticky event bits in one status word. A single level interrupt line is raised when any status bit meets its enable bit.

Clearing the enable bit in the control register acts as a soft reset. The control word just written is kept. Every other register is cleared and both FIFOs are emptied. The block also gives the engine a one-cycle pulse so that it can drop its own burst state. Reading the receive port while it is empty returns a fixed poison word, so software never gets stale data.

Top module: `spi_regfront`

## Requirements
- R1: The register index is reg_addr shifted right by 2 (the low two bits are ignored). The map is 0 control, 1 configuration, 2 interrupt enable, 3 status, 4 TX port, 5 RX port, 6 DMA, 7 period, 8 test. Writes to an index above 8 are ignored and reads there return 0. reg_rdata is valid on the clock edge after reg_re.
- R2: Control (index 0), configuration, interrupt enable, DMA, period and test each store the full 32-bit written word and read it back unchanged. Bit 0 of control is the enable bit.
- R3: The status word (index 3) has these flags: bit 0 TX FIFO empty, bit 1 TX FIFO not full, bit 2 RX FIFO not empty, bit 3 RX FIFO full, bit 4 TX FIFO full. Each flag reflects the FIFO state from the clock edge after the access that changed it.
- R4: Status bit 6 is set when the engine pushes into a full RX FIFO (the word is dropped). Status bit 7 is set by a pulse on xfer_done_i. Writing 1 clears bits 6 and 7. Writes to every other status bit are ignored.
- R5: irq_o is high one clock after any status bit and the same bit of the interrupt-enable register are both set, and it is low one clock after no such pair exists.
- R6: While enabled, a read of the RX port pops the oldest RX word, or returns 0xDEADBEEF if the RX FIFO is empty. While disabled, the read returns 0 and pops nothing.
- R7: A read of the TX port returns 0. A write to the RX port changes nothing.
- R8: A TX port write is dropped when control bit 0 is clear or the TX FIFO is full. Otherwise the words reach tx_data_o in write order, with tx_valid_o high while the FIFO is not empty and tx_pop_i removing the head.
- R9: Writing control with bit 0 clear is a soft reset. Control takes the written word, and the other registers read 0. Status reads 0x00000003, both FIFOs are emptied, and soft_rst_o pulses high for one cycle.
- R10: A hard reset (rst high) gives the same state as a soft reset, except that control reads 0 and irq_o is low.
- R11: Words pushed by the engine into the RX FIFO are read back from the RX port in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_re | input | 1 | Register read strobe |
| reg_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level interrupt request |
| tx_valid_o | output | 1 | TX FIFO holds a word |
| tx_data_o | output | DATA_W | Oldest TX word |
| tx_pop_i | input | 1 | Engine takes the TX head |
| rx_push_i | input | 1 | Engine delivers a received word |
| rx_data_i | input | DATA_W | Received word |
| xfer_done_i | input | 1 | Engine reports a finished transfer |
| ctrl_o | output | DATA_W | Control register contents |
| cfg_o | output | DATA_W | Configuration register contents |
| soft_rst_o | output | 1 | One-cycle pulse after a soft reset |

## Verification
A register read returns data one edge after the strobe, and the bench samples it at the falling edge that follows. Status flags and the FIFO outputs change on the edge that takes the access or engine handshake. Because of this, a status read issued right after a stimulus already sees the new value. irq_o is registered from the status word and is due on the second edge after the stimulus, so the bench waits one extra falling edge before it samples the line. soft_rst_o is checked on the falling edge just after the control write. The expected status words are computed from FIFO fill counts that the bench keeps itself. The FIFO depth is reduced to four so that the fill sweeps reach full and overflow.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;

  typedef enum logic [3:0] {
    RG_CTRL   = 4'd0,
    RG_CFG    = 4'd1,
    RG_IRQEN  = 4'd2,
    RG_STATUS = 4'd3,
    RG_TXPORT = 4'd4,
    RG_RXPORT = 4'd5,
    RG_DMA    = 4'd6,
    RG_PERIOD = 4'd7,
    RG_TEST   = 4'd8
  } reg_idx_e;

  localparam int NUM_REGS = 9;

  localparam int ST_TX_EMPTY = 0;
  localparam int ST_TX_SPACE = 1;
  localparam int ST_RX_READY = 2;
  localparam int ST_RX_FULL  = 3;
  localparam int ST_TX_FULL  = 4;
  localparam int ST_RX_OVF   = 6;
  localparam int ST_DONE     = 7;

  localparam logic [31:0] RX_POISON = 32'hDEAD_BEEF;

endpackage

// File: rtl/spi_rf_fifo.sv
module spi_rf_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign rdata   = mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/spi_rf_status.sv
module spi_rf_status
  import spi_regfront_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tx_empty,
  input  logic              tx_full,
  input  logic              rx_empty,
  input  logic              rx_full,
  input  logic              ovf_set,
  input  logic              done_set,
  input  logic              w1c_en,
  input  logic [DATA_W-1:0] w1c_mask,
  input  logic [DATA_W-1:0] irq_en,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  logic ovf_q, done_q, irq_q;
  logic ovf_clr, done_clr;

  assign ovf_clr  = w1c_en && w1c_mask[ST_RX_OVF];
  assign done_clr = w1c_en && w1c_mask[ST_DONE];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ovf_q  <= ovf_set  || (ovf_q  && !ovf_clr);
      done_q <= done_set || (done_q && !done_clr);
    end
  end

  always_comb begin
    status_o              = '0;
    status_o[ST_TX_EMPTY] = tx_empty;
    status_o[ST_TX_SPACE] = !tx_full;
    status_o[ST_RX_READY] = !rx_empty;
    status_o[ST_RX_FULL]  = rx_full;
    status_o[ST_TX_FULL]  = tx_full;
    status_o[ST_RX_OVF]   = ovf_q;
    status_o[ST_DONE]     = done_q;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status_o & irq_en);
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
  import spi_regfront_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_re,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_pop_i,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              xfer_done_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic              soft_rst_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] ctrl_q, cfg_q, irqen_q, dma_q, period_q, test_q;
  logic [DATA_W-1:0] rdata_q, status_w, rx_head;
  logic              soft_q, enabled, soft_go;
  logic              wr_ctrl, wr_tx, wr_stat, rd_rx;
  logic              tx_empty, tx_full, rx_empty, rx_full;

  assign idx     = reg_addr[ADDR_W-1:2];
  assign enabled = ctrl_q[0];
  assign wr_ctrl = reg_we && (idx == IDX_W'(RG_CTRL));
  assign wr_tx   = reg_we && (idx == IDX_W'(RG_TXPORT)) && enabled;
  assign wr_stat = reg_we && (idx == IDX_W'(RG_STATUS));
  assign rd_rx   = reg_re && (idx == IDX_W'(RG_RXPORT)) && enabled && !rx_empty;
  assign soft_go = wr_ctrl && !reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_go) begin
      cfg_q    <= '0;
      irqen_q  <= '0;
      dma_q    <= '0;
      period_q <= '0;
      test_q   <= '0;
    end else if (reg_we) begin
      case (idx)
        IDX_W'(RG_CFG):    cfg_q    <= reg_wdata;
        IDX_W'(RG_IRQEN):  irqen_q  <= reg_wdata;
        IDX_W'(RG_DMA):    dma_q    <= reg_wdata;
        IDX_W'(RG_PERIOD): period_q <= reg_wdata;
        IDX_W'(RG_TEST):   test_q   <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) soft_q <= 1'b0;
    else     soft_q <= soft_go;
  end

  spi_rf_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk(clk), .rst(rst), .clr(soft_go),
    .push(wr_tx), .wdata(reg_wdata),
    .pop(tx_pop_i), .rdata(tx_data_o),
    .empty(tx_empty), .full(tx_full)
  );

  spi_rf_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk(clk), .rst(rst), .clr(soft_go),
    .push(rx_push_i), .wdata(rx_data_i),
    .pop(rd_rx), .rdata(rx_head),
    .empty(rx_empty), .full(rx_full)
  );

  spi_rf_status #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst(rst), .clr(soft_go),
    .tx_empty(tx_empty), .tx_full(tx_full),
    .rx_empty(rx_empty), .rx_full(rx_full),
    .ovf_set(rx_push_i && rx_full), .done_set(xfer_done_i),
    .w1c_en(wr_stat), .w1c_mask(reg_wdata),
    .irq_en(irqen_q), .status_o(status_w), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_re) begin
      case (idx)
        IDX_W'(RG_CTRL):   rdata_q <= ctrl_q;
        IDX_W'(RG_CFG):    rdata_q <= cfg_q;
        IDX_W'(RG_IRQEN):  rdata_q <= irqen_q;
        IDX_W'(RG_STATUS): rdata_q <= status_w;
        IDX_W'(RG_RXPORT): rdata_q <= !enabled ? '0 :
                                      (rx_empty ? DATA_W'(RX_POISON) : rx_head);
        IDX_W'(RG_DMA):    rdata_q <= dma_q;
        IDX_W'(RG_PERIOD): rdata_q <= period_q;
        IDX_W'(RG_TEST):   rdata_q <= test_q;
        default:           rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata  = rdata_q;
  assign tx_valid_o = !tx_empty;
  assign ctrl_o     = ctrl_q;
  assign cfg_o      = cfg_q;
  assign soft_rst_o = soft_q;

endmodule

// File: rtl/spi_regfront_chk.sv
module spi_regfront_chk
  import spi_regfront_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              reg_re,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_o,
  input logic              tx_pop_i,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] irqen_q,
  input logic [$clog2(FIFO_DEPTH):0] tx_cnt,
  input logic [$clog2(FIFO_DEPTH):0] rx_cnt
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int CW    = $clog2(FIFO_DEPTH) + 1;
  logic [IDX_W-1:0] idx;
  assign idx = reg_addr[ADDR_W-1:2];

  // R1
  out_of_range_chk: assert property (@(posedge clk) disable iff (rst)
    reg_re && (idx >= IDX_W'(NUM_REGS)) |=> reg_rdata == '0);

  // R5
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (irqen_q == '0) |=> !irq_o);

  // R6
  rx_poison_chk: assert property (@(posedge clk) disable iff (rst)
    reg_re && (idx == IDX_W'(RG_RXPORT)) && ctrl_q[0] && (rx_cnt == '0)
    |=> reg_rdata == DATA_W'(RX_POISON));

  // R7
  tx_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_re && (idx == IDX_W'(RG_TXPORT)) |=> reg_rdata == '0);

  // R8
  tx_drop_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we && (idx == IDX_W'(RG_TXPORT)) && (!ctrl_q[0] || tx_cnt == CW'(FIFO_DEPTH))
    && !(tx_pop_i && tx_cnt != '0) |=> $stable(tx_cnt));

  // R9
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we && (idx == IDX_W'(RG_CTRL)) && !reg_wdata[0]
    |=> (tx_cnt == '0) && (rx_cnt == '0) && (ctrl_q == $past(reg_wdata)));

endmodule

bind spi_regfront spi_regfront_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata),
  .irq_o(irq_o), .tx_pop_i(tx_pop_i), .ctrl_q(ctrl_q), .irqen_q(irqen_q),
  .tx_cnt(u_txf.cnt_q), .rx_cnt(u_rxf.cnt_q)
);

// File: tb/spi_regfront_bench.sv
module spi_regfront_bench;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] reg_addr = '0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq_o, tx_valid_o, soft_rst_o;
  logic [DW-1:0] tx_data_o, ctrl_o, cfg_o;
  logic tx_pop_i = 1'b0, rx_push_i = 1'b0, xfer_done_i = 1'b0;
  logic [DW-1:0] rx_data_i = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_regfront #(.ADDR_W(AW), .DATA_W(DW), .FIFO_DEPTH(DEPTH)) u_spi_regfront (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
    .tx_pop_i(tx_pop_i), .rx_push_i(rx_push_i), .rx_data_i(rx_data_i),
    .xfer_done_i(xfer_done_i), .ctrl_o(ctrl_o), .cfg_o(cfg_o),
    .soft_rst_o(soft_rst_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] st(input int tx, input int rx, input bit ovf, input bit done);
    logic [DW-1:0] s = '0;
    s[0] = (tx == 0);
    s[1] = (tx != DEPTH);
    s[2] = (rx != 0);
    s[3] = (rx == DEPTH);
    s[4] = (tx == DEPTH);
    s[6] = ovf;
    s[7] = done;
    return s;
  endfunction

  task automatic wr(input int idx, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = AW'(idx << 2); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = AW'(idx << 2); reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic eng_push(input logic [DW-1:0] d);
    @(negedge clk);
    rx_data_i = d; rx_push_i = 1'b1;
    @(negedge clk);
    rx_push_i = 1'b0;
  endtask

  task automatic eng_pop(output logic [DW-1:0] d);
    @(negedge clk);
    d = tx_data_o; tx_pop_i = 1'b1;
    @(negedge clk);
    tx_pop_i = 1'b0;
  endtask

  task automatic eng_done();
    @(negedge clk);
    xfer_done_i = 1'b1;
    @(negedge clk);
    xfer_done_i = 1'b0;
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [DW-1:0] pats [4];
    int tx, rx;
    bit ovf, done;
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_5A5A;
    pats[2] = 32'h0000_0001; pats[3] = 32'h8000_0000;

    hard_reset();
    // R10 reset state of every register
    chk("R10 irq after reset", DW'(irq_o), 0);
    for (int i = 0; i < 9; i++) begin
      rd(i, d);
      chk("R10 reset register", d, (i == 3) ? 32'h3 : 32'h0);
    end

    // R8 TX write while disabled is dropped
    wr(4, 32'hAA);
    chk("R8 disabled tx_valid", DW'(tx_valid_o), 0);
    rd(3, d); chk("R8 disabled status", d, st(0, 0, 0, 0));
    // R6 disabled RX read returns 0
    rd(5, d); chk("R6 disabled rx read", d, 0);

    // R1 out-of-range accesses
    wr(12, 32'h55);
    rd(12, d); chk("R1 out of range 12", d, 0);
    rd(15, d); chk("R1 out of range 15", d, 0);
    rd(3, d);  chk("R1 out of range no side effect", d, st(0, 0, 0, 0));

    wr(0, 32'h1);
    rd(0, d); chk("R2 ctrl readback", d, 32'h1);

    // R2 full-word storage of plain registers
    foreach (pats[p]) begin
      for (int k = 0; k < 5; k++) begin
        int ri;
        ri = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 6 : (k == 3) ? 7 : 8;
        wr(ri, pats[p] ^ DW'(k));
        rd(ri, d); chk("R2 plain register", d, pats[p] ^ DW'(k));
      end
    end
    wr(2, 32'h0);
    chk("R2 cfg_o", cfg_o, pats[3] ^ 32'h0);

    // R3/R8 TX fill sweep, fifth write dropped
    for (int k = 1; k <= DEPTH + 1; k++) begin
      wr(4, 32'h100 + DW'(k));
      tx = (k > DEPTH) ? DEPTH : k;
      rd(3, d); chk("R3 tx fill status", d, st(tx, 0, 0, 0));
    end
    for (int k = 1; k <= DEPTH; k++) begin
      chk("R8 tx_valid before pop", DW'(tx_valid_o), 1);
      eng_pop(d);
      chk("R8 tx order", d, 32'h100 + DW'(k));
      rd(3, d); chk("R3 tx drain status", d, st(DEPTH - k, 0, 0, 0));
    end
    chk("R8 tx_valid empty", DW'(tx_valid_o), 0);

    // R3/R4 RX fill sweep with overflow
    ovf = 0;
    for (int k = 1; k <= DEPTH + 1; k++) begin
      eng_push(32'h200 + DW'(k));
      rx = (k > DEPTH) ? DEPTH : k;
      ovf = (k > DEPTH);
      rd(3, d); chk("R4 rx fill / overflow status", d, st(0, rx, ovf, 0));
    end
    // R11 RX order, R6 pop
    for (int k = 1; k <= DEPTH; k++) begin
      rd(5, d); chk("R11 rx order", d, 32'h200 + DW'(k));
      rd(3, d); chk("R6 rx pop status", d, st(0, DEPTH - k, 1, 0));
    end
    rd(5, d); chk("R6 empty rx poison", d, 32'hDEAD_BEEF);

    // R4 write-one-to-clear semantics
    eng_done();
    done = 1;
    rd(3, d); chk("R4 done set", d, st(0, 0, 1, 1));
    wr(3, 32'hFFFF_FF3F);
    rd(3, d); chk("R4 other bits ignore writes", d, st(0, 0, 1, 1));
    wr(3, 32'h40);
    rd(3, d); chk("R4 overflow cleared alone", d, st(0, 0, 0, 1));
    wr(3, 32'h80);
    rd(3, d); chk("R4 done cleared", d, st(0, 0, 0, 0));

    // R7 TX port reads 0, RX port writes ignored
    wr(4, 32'h333);
    rd(4, d); chk("R7 tx port read", d, 0);
    wr(5, 32'h777);
    rd(3, d); chk("R7 rx write no status change", d, st(1, 0, 0, 0));
    rd(5, d); chk("R7 rx write not queued", d, 32'hDEAD_BEEF);

    // R5 interrupt on rx-ready
    wr(2, 32'h4);
    @(negedge clk); chk("R5 irq low rx empty", DW'(irq_o), 0);
    eng_push(32'h5);
    @(negedge clk); chk("R5 irq high rx ready", DW'(irq_o), 1);
    rd(5, d);
    @(negedge clk); chk("R5 irq low after pop", DW'(irq_o), 0);
    // R5 interrupt on tx-empty
    wr(2, 32'h1);
    @(negedge clk); chk("R5 irq low tx busy", DW'(irq_o), 0);
    eng_pop(d);
    @(negedge clk); chk("R5 irq high tx empty", DW'(irq_o), 1);
    wr(2, 32'h0);
    @(negedge clk); chk("R5 irq masked", DW'(irq_o), 0);

    // R9 soft reset
    wr(1, 32'hCAFE);
    wr(6, 32'h1234);
    wr(4, 32'h9); wr(4, 32'hA);
    eng_push(32'hB);
    eng_done();
    wr(0, 32'h1234_5670);
    chk("R9 soft_rst_o pulse", DW'(soft_rst_o), 1);
    chk("R9 tx emptied", DW'(tx_valid_o), 0);
    @(negedge clk);
    chk("R9 soft_rst_o one cycle", DW'(soft_rst_o), 0);
    rd(0, d); chk("R9 ctrl kept", d, 32'h1234_5670);
    rd(1, d); chk("R9 cfg cleared", d, 0);
    rd(6, d); chk("R9 dma cleared", d, 0);
    rd(3, d); chk("R9 status", d, 32'h3);
    rd(5, d); chk("R9 R6 rx read while disabled", d, 0);

    // R10 hard reset clears control too
    wr(0, 32'h1);
    wr(1, 32'h77);
    hard_reset();
    rd(0, d); chk("R10 ctrl cleared", d, 0);
    rd(1, d); chk("R10 cfg cleared", d, 0);
    rd(3, d); chk("R10 status", d, 32'h3);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule